// File: doc/BRIEF.md
# DMA Channel Request Source Selector

This block sits between a DMA channel's transfer scheduler and the peripheral request lines of the chip. It decides what paces each transfer of the channel. In memory-to-memory mode the read port is kept busy for as long as bytes remain. In peripheral mode, one request line is picked out of a wide vector by an index, and that request is steered to either the read port or the write port. The block then returns a one-cycle acknowledge to the peripheral that was served.

The handshake is either per burst or per block. In peripheral flow-control mode the peripheral may close the block before the programmed count runs out. The block reports this as an early-end pulse. In this mode the transfer is always peripheral-to-memory, so the request always goes to the read port. All configuration is taken in on the cycle the channel enable rises and is held until the channel is re-enabled.

Top module: `chan_req_router`

## Requirements
- R1: Out of reset, and while the channel enable has not yet been registered, rdReq, wrReq, perAck and earlyEnd are all 0.
- R2: cfgSwReq, cfgDstReq, cfgBlkReq, cfgPfc and cfgReqSel are captured on the clock edge at which chanEn is first seen high. They take effect from the following cycle. Changes to them while chanEn stays high have no effect.
- R3: In software mode (captured cfgSwReq=1), rdReq equals bytesRemain while the channel is active, and wrReq is 0. perAck and earlyEnd stay 0, and perReq and perEnd are ignored.
- R4: In peripheral mode (cfgSwReq=0), only line perReq[cfgReqSel] can start a request. All other request lines are ignored.
- R5: In peripheral mode with cfgPfc=0, cfgDstReq=0 routes the request to rdReq and cfgDstReq=1 routes it to wrReq. rdReq and wrReq are never high together.
- R6: With cfgBlkReq=0, the port request goes high in the same cycle that the selected line is seen, and it stays high until a burstDone strobe, even if the peripheral drops its line. In the cycle after burstDone, perAck has exactly bit cfgReqSel set for one cycle, and the port request is 0 in that cycle.
- R7: With cfgBlkReq=1, burstDone strobes do not end the request. The request is held until blockDone, and the acknowledge follows it with the same timing as in R6.
- R8: With cfgPfc=1, cfgDstReq is treated as 0, so wrReq never rises. A perEnd[cfgReqSel] pulse while a request is being served gives earlyEnd=1 and the acknowledge together in the next cycle.
- R9: With cfgPfc=0, perEnd has no effect: earlyEnd stays 0 and the request is still held.
- R10: When chanEn falls, rdReq, wrReq and perAck drop in the same cycle, and any request in progress is abandoned. It is not resumed when the channel is enabled again.
- R11: While bytesRemain is 0, a selected peripheral request does not start a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanEn | input | 1 | Channel enable; its rising edge captures the configuration |
| cfgSwReq | input | 1 | 1 = memory-to-memory, software paced |
| cfgDstReq | input | 1 | 1 = selected request paces the write port |
| cfgBlkReq | input | 1 | 1 = one handshake per block, 0 = per burst |
| cfgPfc | input | 1 | 1 = peripheral flow control (peripheral may end block early) |
| cfgReqSel | input | SEL_W | Index of the peripheral request line |
| perReq | input | 2**SEL_W | Peripheral request lines |
| perEnd | input | 2**SEL_W | Peripheral end-of-block indications (flow-control mode) |
| burstDone | input | 1 | Scheduler strobe: a burst finished |
| blockDone | input | 1 | Scheduler strobe: a block finished |
| bytesRemain | input | 1 | Scheduler flag: block byte count not yet exhausted |
| rdReq | output | 1 | Request to the read-port scheduler |
| wrReq | output | 1 | Request to the write-port scheduler |
| perAck | output | 2**SEL_W | One-hot acknowledge to the served peripheral |
| earlyEnd | output | 1 | Block closed early by the peripheral |

## Verification
The hardest situation to reach from the ports is a served request that must outlive its own cause. The peripheral drops its line, and then burstDone (in block mode), perEnd (without flow control) or a new configuration value (while enabled) arrives. None of these may end or alter the request. The directed tasks drive the selected line for one cycle only and then apply each of these distractor inputs while the request is held. After each one they sample the port request, and they keep the real completion strobe until last. Dropping the enable in the middle of a served request, and then enabling again with the line low, shows that the held state has been cleared.

// File: rtl/chanreq_pkg.sv
package chanreq_pkg;

  typedef struct packed {
    logic sw;
    logic dst;
    logic blk;
    logic pfc;
  } reqCfg_t;

  typedef struct packed {
    logic capture;
    logic portReq;
    logic ackPulse;
    logic earlyPulse;
  } ctlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_ACK   = 2'd2
  } reqState_e;

endpackage

// File: rtl/chanreq_datapath.sv
module chanreq_datapath
  import chanreq_pkg::*;
#(
  parameter int SEL_W = 7,
  localparam int NUM_REQ = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  reqCfg_t            cfgIn,
  input  logic [SEL_W-1:0]   selIn,
  input  logic [NUM_REQ-1:0] perReq,
  input  logic [NUM_REQ-1:0] perEnd,
  input  ctlStrb_t           strb,
  output reqCfg_t            cfgQ,
  output logic               selReq,
  output logic               selEnd,
  output logic               rdReq,
  output logic               wrReq,
  output logic [NUM_REQ-1:0] perAck,
  output logic               earlyEnd
);

  logic [SEL_W-1:0] selQ;
  logic             toWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      selQ <= '0;
    end else if (strb.capture) begin
      cfgQ <= cfgIn;
      selQ <= selIn;
    end
  end

  assign selReq = perReq[selQ];
  assign selEnd = perEnd[selQ];

  // flow control forces peripheral-to-memory
  assign toWrite = !cfgQ.sw && cfgQ.dst && !cfgQ.pfc;
  assign rdReq   = strb.portReq && !toWrite;
  assign wrReq   = strb.portReq && toWrite;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_ack
    assign perAck[i] = strb.ackPulse && (selQ == SEL_W'(i));
  end

  assign earlyEnd = strb.earlyPulse;

endmodule

// File: rtl/chanreq_control.sv
module chanreq_control
  import chanreq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     chanEn,
  input  reqCfg_t  cfgQ,
  input  logic     selReq,
  input  logic     selEnd,
  input  logic     burstDone,
  input  logic     blockDone,
  input  logic     bytesRemain,
  output ctlStrb_t strb
);

  reqState_e stateQ, stateD;
  logic      activeQ;
  logic      earlyQ, earlyD;
  logic      live;
  logic      doneHit;
  logic      endHit;

  assign live    = activeQ && chanEn;
  assign doneHit = cfgQ.blk ? blockDone : burstDone;
  assign endHit  = cfgQ.pfc && selEnd;

  always_comb begin
    stateD = stateQ;
    earlyD = earlyQ;
    if (!live) begin
      stateD = ST_IDLE;
      earlyD = 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          earlyD = 1'b0;
          if (!cfgQ.sw && selReq && bytesRemain) stateD = ST_SERVE;
        end
        ST_SERVE: begin
          if (doneHit || endHit) begin
            stateD = ST_ACK;
            earlyD = endHit;
          end
        end
        ST_ACK:  stateD = ST_IDLE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      activeQ <= 1'b0;
      earlyQ  <= 1'b0;
    end else begin
      stateQ  <= stateD;
      activeQ <= chanEn;
      earlyQ  <= earlyD;
    end
  end

  always_comb begin
    strb.capture    = chanEn && !activeQ;
    if (cfgQ.sw)
      strb.portReq  = live && bytesRemain;
    else
      strb.portReq  = live && ((stateQ == ST_IDLE && selReq && bytesRemain)
                               || stateQ == ST_SERVE);
    strb.ackPulse   = live && !cfgQ.sw && stateQ == ST_ACK;
    strb.earlyPulse = strb.ackPulse && earlyQ;
  end

endmodule

// File: rtl/chan_req_router.sv
module chan_req_router
  import chanreq_pkg::*;
#(
  parameter int SEL_W = 7,
  localparam int NUM_REQ = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chanEn,
  input  logic               cfgSwReq,
  input  logic               cfgDstReq,
  input  logic               cfgBlkReq,
  input  logic               cfgPfc,
  input  logic [SEL_W-1:0]   cfgReqSel,
  input  logic [NUM_REQ-1:0] perReq,
  input  logic [NUM_REQ-1:0] perEnd,
  input  logic               burstDone,
  input  logic               blockDone,
  input  logic               bytesRemain,
  output logic               rdReq,
  output logic               wrReq,
  output logic [NUM_REQ-1:0] perAck,
  output logic               earlyEnd
);

  reqCfg_t  cfgIn;
  reqCfg_t  cfgQ;
  ctlStrb_t strb;
  logic     selReq;
  logic     selEnd;

  assign cfgIn = '{sw: cfgSwReq, dst: cfgDstReq, blk: cfgBlkReq, pfc: cfgPfc};

  chanreq_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .chanEn      (chanEn),
    .cfgQ        (cfgQ),
    .selReq      (selReq),
    .selEnd      (selEnd),
    .burstDone   (burstDone),
    .blockDone   (blockDone),
    .bytesRemain (bytesRemain),
    .strb        (strb)
  );

  chanreq_datapath #(.SEL_W(SEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgIn    (cfgIn),
    .selIn    (cfgReqSel),
    .perReq   (perReq),
    .perEnd   (perEnd),
    .strb     (strb),
    .cfgQ     (cfgQ),
    .selReq   (selReq),
    .selEnd   (selEnd),
    .rdReq    (rdReq),
    .wrReq    (wrReq),
    .perAck   (perAck),
    .earlyEnd (earlyEnd)
  );

endmodule

// File: rtl/chan_req_router_chk.sv
module chan_req_router_chk
  import chanreq_pkg::*;
#(
  parameter int SEL_W = 7,
  localparam int NUM_REQ = 1 << SEL_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               chanEn,
  input reqCfg_t            cfgQ,
  input logic               rdReq,
  input logic               wrReq,
  input logic [NUM_REQ-1:0] perAck,
  input logic               earlyEnd
);

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq)); // R5

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(perAck)); // R6

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|perAck) |-> $past(rdReq || wrReq)); // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|perAck) |=> !(|perAck)); // R6

  AST_EARLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    earlyEnd |-> (|perAck)); // R8

  AST_PFC_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.pfc && !cfgQ.sw) |-> !wrReq); // R8

  AST_SW_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.sw |-> (!(|perAck) && !earlyEnd && !wrReq)); // R3

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> (!rdReq && !wrReq && !(|perAck))); // R10

endmodule

bind chan_req_router chan_req_router_chk #(.SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chanEn   (chanEn),
  .cfgQ     (cfgQ),
  .rdReq    (rdReq),
  .wrReq    (wrReq),
  .perAck   (perAck),
  .earlyEnd (earlyEnd)
);

// File: tb/chan_req_router_tb.sv
module chan_req_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W      = 7;
  localparam int NUM_REQ    = 1 << SEL_W;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               chanEn = 1'b0;
  logic               cfgSwReq = 1'b0, cfgDstReq = 1'b0, cfgBlkReq = 1'b0, cfgPfc = 1'b0;
  logic [SEL_W-1:0]   cfgReqSel = '0;
  logic [NUM_REQ-1:0] perReq = '0, perEnd = '0;
  logic               burstDone = 1'b0, blockDone = 1'b0, bytesRemain = 1'b0;
  logic               rdReq, wrReq, earlyEnd;
  logic [NUM_REQ-1:0] perAck;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_req_router #(.SEL_W(SEL_W)) u_dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn),
    .cfgSwReq(cfgSwReq), .cfgDstReq(cfgDstReq), .cfgBlkReq(cfgBlkReq), .cfgPfc(cfgPfc),
    .cfgReqSel(cfgReqSel), .perReq(perReq), .perEnd(perEnd),
    .burstDone(burstDone), .blockDone(blockDone), .bytesRemain(bytesRemain),
    .rdReq(rdReq), .wrReq(wrReq), .perAck(perAck), .earlyEnd(earlyEnd)
  );

  task automatic chk(input string req, input logic [NUM_REQ-1:0] act,
                     input logic [NUM_REQ-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, look 1 time unit later
  task automatic nextCycle();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  function automatic logic [NUM_REQ-1:0] bitAt(input int idx);
    logic [NUM_REQ-1:0] v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  task automatic enable(input logic sw, input logic dst, input logic blk,
                        input logic pfc, input int sel);
    nextCycle();
    chanEn = 1'b0; perReq = '0; perEnd = '0; burstDone = 0; blockDone = 0;
    nextCycle();
    cfgSwReq = sw; cfgDstReq = dst; cfgBlkReq = blk; cfgPfc = pfc;
    cfgReqSel = SEL_W'(sel);
    chanEn = 1'b1;
    settle();
    chk("R1 quiet in enable cycle", {rdReq, wrReq, earlyEnd, |perAck}, '0);
  endtask

  task automatic t_reset();
    settle();
    chk("R1 reset rdReq/wrReq/earlyEnd", {rdReq, wrReq, earlyEnd}, '0);
    chk("R1 reset perAck", perAck, '0);
  endtask

  task automatic t_software();
    enable(1'b1, 1'b1, 1'b0, 1'b0, 3);
    nextCycle();
    bytesRemain = 1; perReq = '1; perEnd = '1;
    cfgSwReq = 0; cfgDstReq = 1;  // R2: changes while enabled ignored
    settle();
    chk("R3 sw rdReq follows bytesRemain", rdReq, 1);
    chk("R3 sw wrReq low", wrReq, 0);
    nextCycle();
    settle();
    chk("R2 config held while enabled", {rdReq, wrReq}, 2'b10);
    chk("R3 sw no ack/earlyEnd", {|perAck, earlyEnd}, '0);
    bytesRemain = 0;
    settle();
    chk("R3 sw rdReq drops with bytesRemain", rdReq, 0);
    perReq = '0; perEnd = '0;
  endtask

  task automatic t_burst_read();
    enable(1'b0, 1'b0, 1'b0, 1'b0, 5);
    nextCycle();
    bytesRemain = 1; perReq = bitAt(6);
    settle();
    chk("R4 unselected line ignored", {rdReq, wrReq}, 2'b00);
    perReq = bitAt(5);
    settle();
    chk("R6 request seen same cycle", rdReq, 1);
    nextCycle();
    perReq = '0;
    settle();
    chk("R6 request held after line drops", rdReq, 1);
    burstDone = 1;
    nextCycle();
    burstDone = 0;
    settle();
    chk("R6 ack onehot at selected index", perAck, bitAt(5));
    chk("R6 port request low in ack cycle", {rdReq, earlyEnd}, 2'b00);
    nextCycle();
    settle();
    chk("R6 ack lasts one cycle", perAck, '0);
  endtask

  task automatic t_block_write();
    enable(1'b0, 1'b1, 1'b1, 1'b0, 127);
    nextCycle();
    bytesRemain = 1; perReq = bitAt(127);
    settle();
    chk("R5 dst=1 routes to write port", {rdReq, wrReq}, 2'b01);
    nextCycle();
    perReq = '0; burstDone = 1;
    nextCycle();
    burstDone = 0;
    settle();
    chk("R7 burstDone does not end block request", {wrReq, |perAck}, 2'b10);
    blockDone = 1;
    nextCycle();
    blockDone = 0;
    settle();
    chk("R7 ack after blockDone", perAck, bitAt(127));
    chk("R5 write port low in ack cycle", wrReq, 0);
  endtask

  task automatic t_pfc_early();
    enable(1'b0, 1'b1, 1'b0, 1'b1, 9);
    nextCycle();
    bytesRemain = 1; perReq = bitAt(9);
    settle();
    chk("R8 pfc forces read port", {rdReq, wrReq}, 2'b10);
    nextCycle();
    perReq = '0; perEnd = bitAt(9);
    nextCycle();
    perEnd = '0;
    settle();
    chk("R8 earlyEnd pulse", earlyEnd, 1);
    chk("R8 ack with early end", perAck, bitAt(9));
    nextCycle();
    settle();
    chk("R8 earlyEnd one cycle", earlyEnd, 0);
  endtask

  task automatic t_no_pfc_end();
    enable(1'b0, 1'b0, 1'b0, 1'b0, 9);
    nextCycle();
    bytesRemain = 1; perReq = bitAt(9);
    nextCycle();
    perReq = '0; perEnd = bitAt(9);
    nextCycle();
    perEnd = '0;
    settle();
    chk("R9 perEnd ignored without pfc", {earlyEnd, |perAck, rdReq}, 3'b001);
    burstDone = 1;
    nextCycle();
    burstDone = 0;
    settle();
    chk("R9 normal ack, no earlyEnd", {earlyEnd, |perAck}, 2'b01);
  endtask

  task automatic t_disable_mid();
    enable(1'b0, 1'b0, 1'b0, 1'b0, 20);
    nextCycle();
    bytesRemain = 1; perReq = bitAt(20);
    nextCycle();
    perReq = '0;
    chanEn = 0;
    settle();
    chk("R10 request drops with enable", {rdReq, wrReq}, 2'b00);
    nextCycle();
    chanEn = 1;
    nextCycle();
    settle();
    chk("R10 request not resumed", {rdReq, wrReq, |perAck}, 3'b000);
  endtask

  task automatic t_no_bytes();
    enable(1'b0, 1'b0, 1'b0, 1'b0, 33);
    nextCycle();
    bytesRemain = 0; perReq = bitAt(33);
    settle();
    chk("R11 no request without bytes", rdReq, 0);
    nextCycle();
    perReq = '0; bytesRemain = 1;
    settle();
    chk("R11 request not latched", rdReq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rstN = 1;
    nextCycle();
    settle();
    chk("R1 outputs quiet after reset release", {rdReq, wrReq, earlyEnd, |perAck}, '0);
    t_software();
    t_burst_read();
    t_block_write();
    t_pfc_early();
    t_no_pfc_end();
    t_disable_mid();
    t_no_bytes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule